// File: doc/BRIEF.md
# Paged Configuration Register File

This block is a byte-wide bank of configuration registers reached through indirect page addressing. A host interface presents a 5-bit address, write data, a write strobe and a read strobe. One fixed address at the top of the address space holds a page pointer. Every other address is decoded against the page that the pointer currently selects. The stored values of all pages leave the block as one flat parallel vector for the rest of the chip.

Six pages are implemented. Page 0 also carries a 10-bit signed phase correction word, which is split over two byte registers. This word is published on a dedicated output only when its upper byte is written, so downstream logic never sees a half-updated value. The block has no power-on reset. Its defaults are only reached by asserting the asynchronous active-low reset input. Release of that reset is synchronised to the clock inside the block.

Top module: `paged_cfg_regs`

## Requirements
- R1: While reset is held, and after it has been released, the page pointer is 0, the phase word is 0 and the read data is 0x00. Register (page p, index i) holds its default `{p[3:0], i[3:0]}`, except that page 0 indices 0 and 1 default to 0x00.
- R2: Address 0x1F writes and reads the page pointer no matter which page is selected. The pointer value is returned zero-extended in the read byte.
- R3: A write of 6 or higher to address 0x1F is ignored and the pointer keeps its previous value. The values 0 to 5 are accepted.
- R4: Addresses 0 to 3 select register index 0 to 3 of the current page. A write changes only that one register.
- R5: Reads from addresses 4 to 0x1E return 0x00. Writes to them change no register and do not change the pointer.
- R6: Read data is registered. It appears one cycle after the read strobe and holds its value until the next read.
- R7: On page 0, index 0 is the low byte and index 1 the high byte of the phase word, whose bits [9:8] are the high byte's bits [1:0]. A write of the low byte leaves the phase output unchanged. A write of the high byte loads the phase output from the written high byte and the stored low byte.
- R8: The flat register output puts register (p, i) at bits `[(p*4+i)*8 +: 8]` and shows a write from the cycle after the write edge.
- R9: A read and a write to the same register in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| page_o | output | 3 | Currently selected page |
| phase_corr_o | output | 10 | Committed signed phase correction word |
| cfg_o | output | 192 | All page registers, flattened |

## Verification
Some rules are checked by the assertions on every cycle. The pointer never leaves the range 0 to 5, and it stays put after an out-of-range write. A read of 0x1F returns the pointer. A read of an unimplemented address returns zero, and a write to one leaves all state unchanged. The phase output moves only on a high-byte commit, and the read data holds between reads. Other behaviour can only be shown by the bench's scenarios with a reference model of every register. This covers the default values, the mapping of page and index onto the flat output, the exact composition of the committed phase word, and the old-value return on a simultaneous read and write.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  // Reset value of register (page, index): page in the high nibble,
  // index in the low nibble; the phase bytes on page 0 start neutral.
  function automatic logic [7:0] pcr_default(int unsigned page, int unsigned idx);
    if (page == 0 && idx < 2) return 8'h00;
    return 8'(((page & 15) << 4) | (idx & 15));
  endfunction

endpackage

// File: rtl/pcr_rst_sync.sv
module pcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pcr_page_ptr.sv
module pcr_page_ptr #(
  parameter int NUM_PAGES = 6,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PAGE_W-1:0] page_o
);
  logic [PAGE_W-1:0] page_d, page_q;
  logic              load;

  always_comb begin
    load   = sel_i && (wdata_i < DATA_W'(NUM_PAGES));
    page_d = page_q;
    if (load) page_d = PAGE_W'(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) page_q <= '0;
    else         page_q <= page_d;
  end

  assign page_o = page_q;

  assert_page_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_o < PAGE_W'(NUM_PAGES));

  assert_page_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wdata_i >= DATA_W'(NUM_PAGES)) |=> $stable(page_o));
endmodule

// File: rtl/pcr_bank.sv
module pcr_bank
  import pcr_pkg::*;
#(
  parameter int NUM_PAGES = 6,
  parameter int REGS      = 4,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int IDX_W     = 2,
  localparam int CFG_W    = NUM_PAGES * REGS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] wpage_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CFG_W-1:0]  regs_o
);
  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    for (genvar r = 0; r < REGS; r++) begin : g_reg
      localparam int SLOT = p * REGS + r;
      logic              hit;
      logic [DATA_W-1:0] reg_d, reg_q;

      always_comb begin
        hit   = we_i && (wpage_i == PAGE_W'(p)) && (widx_i == IDX_W'(r));
        reg_d = reg_q;
        if (hit) reg_d = wdata_i;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) reg_q <= DATA_W'(pcr_default(p, r));
        else         reg_q <= reg_d;
      end

      assign regs_o[SLOT*DATA_W +: DATA_W] = reg_q;
    end
  end
endmodule

// File: rtl/pcr_phase_hold.sv
module pcr_phase_hold #(
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 10,
  localparam int HI_BITS = PHASE_W - DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic [DATA_W-1:0]  lo_i,
  input  logic [DATA_W-1:0]  hi_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_d, phase_q;

  always_comb begin
    phase_d = phase_q;
    if (commit_i) phase_d = {hi_i[HI_BITS-1:0], lo_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/paged_cfg_regs.sv
module paged_cfg_regs #(
  parameter int ADDR_W        = 5,
  parameter int DATA_W        = 8,
  parameter int NUM_PAGES     = 6,
  parameter int REGS_PER_PAGE = 4,
  parameter int PHASE_W       = 10,
  parameter int PAGE_ADDR     = 31,
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int IDX_W  = $clog2(REGS_PER_PAGE),
  localparam int CFG_W  = NUM_PAGES * REGS_PER_PAGE * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [PAGE_W-1:0]  page_o,
  output logic [PHASE_W-1:0] phase_corr_o,
  output logic [CFG_W-1:0]   cfg_o
);
  logic              rst_n;
  logic              is_ptr, is_reg, ptr_we, reg_we, phase_commit;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_val, rdata_d, rdata_q;

  pcr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .arst_ni(rst_ni), .rst_no(rst_n));

  // Address decode
  always_comb begin
    is_ptr       = (addr_i == ADDR_W'(PAGE_ADDR));
    is_reg       = (addr_i < ADDR_W'(REGS_PER_PAGE));
    idx          = IDX_W'(addr_i);
    ptr_we       = wr_en_i && is_ptr;
    reg_we       = wr_en_i && is_reg;
    phase_commit = reg_we && (page_o == '0) && (idx == IDX_W'(1));
  end

  pcr_page_ptr #(.NUM_PAGES(NUM_PAGES), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_n), .sel_i(ptr_we), .wdata_i(wdata_i), .page_o(page_o));

  pcr_bank #(.NUM_PAGES(NUM_PAGES), .REGS(REGS_PER_PAGE), .DATA_W(DATA_W),
             .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(reg_we), .wpage_i(page_o),
    .widx_i(idx), .wdata_i(wdata_i), .regs_o(cfg_o));

  pcr_phase_hold #(.DATA_W(DATA_W), .PHASE_W(PHASE_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_n), .commit_i(phase_commit),
    .lo_i(cfg_o[DATA_W-1:0]), .hi_i(wdata_i), .phase_o(phase_corr_o));

  // Read path: value before any same-cycle write, registered on strobe
  always_comb begin
    int slot;
    slot   = int'(page_o) * REGS_PER_PAGE + int'(idx);
    rd_val = '0;
    if (is_ptr)      rd_val = DATA_W'(page_o);
    else if (is_reg) rd_val = cfg_o[slot*DATA_W +: DATA_W];
    rdata_d = rdata_q;
    if (rd_en_i) rdata_d = rd_val;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  assert_ptr_read_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en_i && is_ptr) |=> rdata_o == DATA_W'($past(page_o)));

  assert_unimpl_read_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en_i && !is_ptr && !is_reg) |=> rdata_o == '0);

  assert_unimpl_write_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && !is_ptr && !is_reg) |=> ($stable(cfg_o) && $stable(page_o)));

  assert_rdata_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));

  assert_phase_atomic_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(wr_en_i && addr_i == ADDR_W'(1) && page_o == '0) |=> $stable(phase_corr_o));
endmodule

// File: tb/paged_cfg_regs_tb.sv
module paged_cfg_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6, NR = 4;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [4:0]  addr;
  logic [7:0]  wdata;
  logic        wr_en, rd_en;
  logic [7:0]  rdata;
  logic [2:0]  page;
  logic [9:0]  phase;
  logic [191:0] cfg;

  int checks = 0, errors = 0;
  logic [7:0] model [NP][NR];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_pend = 1'b0;
  int         cur_page = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_cfg_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .page_o(page),
    .phase_corr_o(phase), .cfg_o(cfg));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_cfg(string tag);
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++)
        chk(tag, 32'(cfg[(p*NR+r)*8 +: 8]), 32'(model[p][r]));
  endtask

  // Monitor: pop one expected byte per read strobe, one cycle later
  always @(posedge clk) rd_pend <= rd_en;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      chk(tag_q.pop_front(), 32'(rdata), 32'(exp_q.pop_front()));
    end
  end

  function automatic logic [7:0] model_read(logic [4:0] a);
    if (a == 5'h1F) return 8'(cur_page);
    if (a < 5'(NR)) return model[cur_page][a[1:0]];
    return 8'h00;
  endfunction

  function automatic void model_write(logic [4:0] a, logic [7:0] d);
    if (a == 5'h1F) begin
      if (d < 8'(NP)) cur_page = int'(d);
    end else if (a < 5'(NR)) model[cur_page][a[1:0]] = d;
  endfunction

  task automatic access(logic [4:0] a, logic [7:0] d, logic w, logic r, string tag);
    @(negedge clk);
    addr = a; wdata = d; wr_en = w; rd_en = r;
    if (r) begin exp_q.push_back(model_read(a)); tag_q.push_back(tag); end
    if (w) model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d, string tag); access(a, d, 1'b1, 1'b0, tag); endtask
  task automatic rd(logic [4:0] a, string tag); access(a, 8'h00, 1'b0, 1'b1, tag); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++)
        model[p][r] = (p == 0 && r < 2) ? 8'h00 : 8'((p << 4) | r);
    rst_ni = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 page in reset", 32'(page), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 page", 32'(page), 0);
    chk("R1 phase", 32'(phase), 0);
    chk("R1 rdata", 32'(rdata), 0);
    chk_cfg("R1 defaults");

    rd(5'h1F, "R2 pointer read page0");
    rd(5'h02, "R4 p0 idx2");
    rd(5'h03, "R4 p0 idx3");

    wr(5'h1F, 8'h03, "R2");
    chk("R2 page set 3", 32'(page), 3);
    rd(5'h1F, "R2 pointer read page3");
    rd(5'h01, "R4 p3 idx1");
    wr(5'h02, 8'hA5, "R4");
    chk_cfg("R8 after p3 write");
    rd(5'h02, "R4 p3 idx2 readback");

    wr(5'h1F, 8'h06, "R3");
    chk("R3 write 6 ignored", 32'(page), 3);
    wr(5'h1F, 8'hFF, "R3");
    chk("R3 write FF ignored", 32'(page), 3);
    wr(5'h1F, 8'h05, "R3");
    chk("R3 write 5 accepted", 32'(page), 5);
    rd(5'h1F, "R2 pointer read page5");
    wr(5'h00, 8'h5A, "R4");
    chk_cfg("R8 after p5 write");

    rd(5'h04, "R5 unimpl addr 4");
    rd(5'h10, "R5 unimpl addr 0x10");
    rd(5'h1E, "R5 unimpl addr 0x1E");
    wr(5'h10, 8'h77, "R5");
    wr(5'h04, 8'h01, "R5");
    chk_cfg("R5 unimpl writes no effect");
    chk("R5 pointer untouched", 32'(page), 5);

    wr(5'h1F, 8'h00, "R2");
    wr(5'h00, 8'h34, "R7");
    chk("R7 low byte alone", 32'(phase), 0);
    wr(5'h01, 8'h02, "R7");
    chk("R7 commit", 32'(phase), 32'h234);
    wr(5'h01, 8'hFF, "R7");
    chk("R7 recommit hi only", 32'(phase), 32'h334);
    wr(5'h00, 8'hFF, "R7");
    chk("R7 new low held back", 32'(phase), 32'h334);
    wr(5'h01, 8'h00, "R7");
    chk("R7 commit new low", 32'(phase), 32'h0FF);
    wr(5'h1F, 8'h02, "R7");
    wr(5'h01, 8'h03, "R7");
    chk("R7 other page no commit", 32'(phase), 32'h0FF);

    access(5'h03, 8'hC3, 1'b1, 1'b1, "R9 same-cycle old value");
    rd(5'h03, "R9 new value after");
    repeat (3) @(negedge clk);
    chk("R6 rdata holds", 32'(rdata), 32'hC3);
    chk_cfg("R8 final");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule